// File: doc/BRIEF.md
# Serial Audio Receiver with Slot and Sample Sizing

This block takes a three-wire serial audio stream (bit clock, word-select, serial data) and turns it into sample words for a receive FIFO, which is not part of this block. The bit clock and word-select either arrive from an external source or are made inside the block from the system clock. In both cases they pass through the same two-stage synchronizer, so all capture logic runs on the system clock and sees one rising-edge event per bit period.

The stream format is set at run time: which word-select level marks the left channel, stereo or single-channel capture, and a compact mode that packs a left/right pair into one word with 16-bit or 8-bit halves. The sample width and the slot width are set separately. Bits of a slot past the sample width are dropped, and each sample is left-aligned with zero fill below it. Format settings take effect only at the start of a left slot. The clock source and the generator settings are taken only while capture is disabled.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset `wrValid`, `bclkOut` and `wsOut` are 0.
- R2: With the internal clock selected, `bclkOut` stays high for `cfgClkDiv`+1 system clocks and low for `cfgClkDiv`+1 system clocks. `wsOut` changes only on a falling edge of `bclkOut`, once every `cfgSlotSize`+1 bit-clock periods.
- R3: Data is sampled on rising bit-clock edges, MSB first. The first bit of a slot is the one sampled on the second rising edge after the word-select change. The last bit of a slot is sampled on the first rising edge after the next change.
- R4: After `enable` rises, capture begins at the first left slot. Earlier slots produce no word.
- R5: With `cfgPolarity`=0, word-select high marks the left channel. With `cfgPolarity`=1, word-select high marks the right channel. In stereo mode each slot gives one word, left before right.
- R6: Only the first min(`cfgSampleSize`,`cfgSlotSize`)+1 bits of a slot are kept. They are placed from bit 31 downward, and every lower bit is 0.
- R7: In single-channel mode (`cfgMono`=1, `cfgCompact`=0), only slots with word-select equal to `cfgPolarity` give words: the low phase for polarity 0 and the high phase for polarity 1.
- R8: In compact mode with `cfgCompact8`=0, one word is written per pair. Bits 15:0 hold bits 31:16 of the left sample, and bits 31:16 hold bits 31:16 of the right sample.
- R9: In compact mode with `cfgCompact8`=1, one word is written per pair. Bits 7:0 hold bits 31:24 of the left sample, bits 15:8 hold bits 31:24 of the right sample, and bits 31:16 are 0.
- R10: A change to polarity, mode, sample size or slot size made while capture is running applies from the next left slot on. The slot already in progress and the right slot that follows keep the old setting.
- R11: While `enable` is 0 no word is written. A left half captured before `enable` fell is discarded and never paired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture enable |
| cfgMaster | input | 1 | 1: generate bit clock and word-select internally |
| cfgClkDiv | input | DIV_W | Bit-clock half period in system clocks, minus one |
| cfgPolarity | input | 1 | Word-select level meaning (see R5, R7) |
| cfgMono | input | 1 | Single-channel capture |
| cfgCompact | input | 1 | Pack a left/right pair into one word |
| cfgCompact8 | input | 1 | Compact halves are 8 bits (else 16) |
| cfgSampleSize | input | 5 | Sample bits minus one |
| cfgSlotSize | input | 5 | Bit periods per word-select phase minus one |
| bclkIn | input | 1 | External bit clock |
| wsIn | input | 1 | External word-select |
| sdIn | input | 1 | Serial data |
| bclkOut | output | 1 | Generated bit clock (0 when external) |
| wsOut | output | 1 | Generated word-select (0 when external) |
| wrValid | output | 1 | One-cycle write strobe to the FIFO |
| wrData | output | 32 | Sample word |

## Verification
The assertions assume that bit-clock edges are at least three system clocks apart, so that no two rising-edge events fall inside the synchronizer window. They also assume that word-select and data change only while the bit clock is low. The bench drives the external clock with four system clocks per half period and changes word-select and data only at the start of the low phase. In internal mode it keeps the data line constant, so every sampled bit is known whatever the phase.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned POS_W  = $clog2(DATA_W);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned QTR_W  = DATA_W / 4;

  typedef enum logic [1:0] {
    PACK_NONE = 2'd0,
    PACK_16   = 2'd1,
    PACK_8    = 2'd2
  } packMode_e;

  // Stream format, applied at left-slot starts.
  typedef struct packed {
    logic             pol;
    logic             mono;
    logic             compact;
    logic             pack8;
    logic [POS_W-1:0] sampleSz;
    logic [POS_W-1:0] slotSz;
  } fmtCfg_t;

  // Strobes from slot control to the sample datapath.
  typedef struct packed {
    logic             bitValid;
    logic             bitVal;
    logic [POS_W-1:0] bitPos;
    logic             sampleDone;
    logic             chanLeft;
    packMode_e        packMode;
    logic             pairClear;
  } rxStrobe_t;

endpackage

// File: rtl/sarx_clkgen.sv
module sarx_clkgen
  import serial_audio_rx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             genOn,
  input  logic [DIV_W-1:0] divLimit,
  input  logic [POS_W-1:0] slotLimit,
  output logic             bclkGen,
  output logic             wsGen
);

  logic [DIV_W-1:0] divCnt;
  logic [POS_W-1:0] genBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      bclkGen <= 1'b0;
      wsGen   <= 1'b0;
      genBit  <= '0;
    end else if (!genOn) begin
      divCnt  <= '0;
      bclkGen <= 1'b0;
      wsGen   <= 1'b0;
      genBit  <= '0;
    end else if (divCnt >= divLimit) begin
      divCnt  <= '0;
      bclkGen <= ~bclkGen;
      if (bclkGen) begin
        if (genBit == slotLimit) begin
          genBit <= '0;
          wsGen  <= ~wsGen;
        end else begin
          genBit <= genBit + 1'b1;
        end
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // R2: word-select moves only together with a falling bit clock
  a_r2_ws_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (genOn && !$stable(wsGen)) |-> $fell(bclkGen));

endmodule

// File: rtl/sarx_ctrl.sv
module sarx_ctrl
  import serial_audio_rx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgMaster,
  input  logic [DIV_W-1:0] cfgDiv,
  input  fmtCfg_t          portCfg,
  input  logic             bclkIn,
  input  logic             wsIn,
  input  logic             sdIn,
  output logic             bclkOut,
  output logic             wsOut,
  output rxStrobe_t        strb
);

  localparam logic [POS_W:0] IDX_MAX = {(POS_W+1){1'b1}};

  // Clock source settings, taken only while idle
  logic             masterAct;
  logic [DIV_W-1:0] divAct;
  logic [POS_W-1:0] genSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterAct <= 1'b0;
      divAct    <= '0;
      genSlot   <= '1;
    end else if (!enable) begin
      masterAct <= cfgMaster;
      divAct    <= cfgDiv;
      genSlot   <= portCfg.slotSz;
    end
  end

  logic bclkGen, wsGen;

  sarx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk       (clk),
    .rstN      (rstN),
    .genOn     (masterAct),
    .divLimit  (divAct),
    .slotLimit (genSlot),
    .bclkGen   (bclkGen),
    .wsGen     (wsGen)
  );

  assign bclkOut = bclkGen;
  assign wsOut   = wsGen;

  // Common synchronizer for both clock sources
  logic       bclkSrc, wsSrc;
  logic [2:0] bclkSync;
  logic [1:0] wsSync, sdSync;
  logic       riseEv;

  assign bclkSrc = masterAct ? bclkGen : bclkIn;
  assign wsSrc   = masterAct ? wsGen   : wsIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkSync <= '0;
      wsSync   <= '0;
      sdSync   <= '0;
    end else begin
      bclkSync <= {bclkSync[1:0], bclkSrc};
      wsSync   <= {wsSync[0], wsSrc};
      sdSync   <= {sdSync[0], sdIn};
    end
  end

  assign riseEv = bclkSync[1] & ~bclkSync[2];

  // Stage 1: per-bit event, word-select delayed by one bit period
  logic wsPrev, wsPrev2;
  logic evValid, evBit, evWs, evStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsPrev  <= 1'b0;
      wsPrev2 <= 1'b0;
      evValid <= 1'b0;
      evBit   <= 1'b0;
      evWs    <= 1'b0;
      evStart <= 1'b0;
    end else begin
      evValid <= riseEv;
      if (riseEv) begin
        wsPrev  <= wsSync[1];
        wsPrev2 <= wsPrev;
        evBit   <= sdSync[1];
        evWs    <= wsPrev;
        evStart <= (wsPrev != wsPrev2);
      end
    end
  end

  // Stage 2: slot position, frame boundary and keep decision
  fmtCfg_t          act, nxtAct;
  logic             running, nxtRunning;
  logic [POS_W:0]   idx, nxtIdx;
  logic             loadNow, chanLeft, wanted, keep;
  logic [POS_W-1:0] limit;
  packMode_e        nxtPack;

  always_comb begin
    loadNow    = evValid && evStart && ((evWs ^ portCfg.pol) == 1'b1) && enable;
    nxtAct     = loadNow ? portCfg : act;
    nxtRunning = enable && (loadNow || running);
    if (!evValid)             nxtIdx = idx;
    else if (evStart)         nxtIdx = '0;
    else if (idx == IDX_MAX)  nxtIdx = idx;
    else                      nxtIdx = idx + 1'b1;
    chanLeft = evWs ^ nxtAct.pol;
    limit    = (nxtAct.sampleSz < nxtAct.slotSz) ? nxtAct.sampleSz : nxtAct.slotSz;
    wanted   = nxtAct.compact || !nxtAct.mono || !chanLeft;
    keep     = evValid && nxtRunning && wanted && (nxtIdx <= {1'b0, limit});
    if (!nxtAct.compact)    nxtPack = PACK_NONE;
    else if (nxtAct.pack8)  nxtPack = PACK_8;
    else                    nxtPack = PACK_16;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      act     <= '{pol: 1'b0, mono: 1'b0, compact: 1'b0, pack8: 1'b0,
                   sampleSz: '1, slotSz: '1};
      running <= 1'b0;
      idx     <= IDX_MAX;
      strb    <= '{bitValid: 1'b0, bitVal: 1'b0, bitPos: '0, sampleDone: 1'b0,
                   chanLeft: 1'b0, packMode: PACK_NONE, pairClear: 1'b1};
    end else begin
      act             <= nxtAct;
      running         <= nxtRunning;
      idx             <= nxtIdx;
      strb.bitValid   <= keep;
      strb.bitVal     <= evBit;
      strb.bitPos     <= nxtIdx[POS_W-1:0];
      strb.sampleDone <= keep && (nxtIdx == {1'b0, limit});
      strb.chanLeft   <= chanLeft;
      strb.packMode   <= nxtPack;
      strb.pairClear  <= !nxtRunning;
    end
  end

  // R11: nothing is captured in the cycle after enable is low
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !strb.bitValid);

  // R4: capture always opens on a left slot
  a_r4_first_left: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> strb.chanLeft);

  // R6: no bit is written past the active sample size
  a_r6_pos_limit: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitValid |-> (strb.bitPos <= act.sampleSz) && (strb.bitPos <= act.slotSz));

endmodule

// File: rtl/sarx_datapath.sv
module sarx_datapath
  import serial_audio_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  output logic              wrValid,
  output logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0] capt, nxtCapt, packWord;
  logic [HALF_W-1:0] pairHold;
  logic              pairHave;

  always_comb begin
    nxtCapt = (strb.bitPos == '0) ? '0 : capt;
    nxtCapt[DATA_W-1-strb.bitPos] = strb.bitVal;
  end

  always_comb begin
    packWord = '0;
    if (strb.packMode == PACK_8) begin
      packWord[QTR_W-1:0]       = pairHold[HALF_W-1 -: QTR_W];
      packWord[2*QTR_W-1:QTR_W] = nxtCapt[DATA_W-1 -: QTR_W];
    end else begin
      packWord = {nxtCapt[DATA_W-1 -: HALF_W], pairHold};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capt     <= '0;
      pairHold <= '0;
      pairHave <= 1'b0;
      wrValid  <= 1'b0;
      wrData   <= '0;
    end else begin
      wrValid <= 1'b0;
      if (strb.pairClear) pairHave <= 1'b0;
      if (strb.bitValid) capt <= nxtCapt;
      if (strb.bitValid && strb.sampleDone) begin
        if (strb.packMode == PACK_NONE) begin
          wrValid <= 1'b1;
          wrData  <= nxtCapt;
        end else if (strb.chanLeft) begin
          pairHold <= nxtCapt[DATA_W-1 -: HALF_W];
          pairHave <= 1'b1;
        end else if (pairHave) begin
          wrValid  <= 1'b1;
          wrData   <= packWord;
          pairHave <= 1'b0;
        end
      end
    end
  end

  // R9: a finished 8-bit pair leaves the upper half of the word clear
  a_r9_pack8_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bitValid && strb.sampleDone && strb.packMode == PACK_8 && !strb.chanLeft && pairHave)
      |=> wrValid && (wrData[DATA_W-1:2*QTR_W] == '0));

  // R3: at most one word per slot, never back to back
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cfgMaster,
  input  logic [DIV_W-1:0]  cfgClkDiv,
  input  logic              cfgPolarity,
  input  logic              cfgMono,
  input  logic              cfgCompact,
  input  logic              cfgCompact8,
  input  logic [POS_W-1:0]  cfgSampleSize,
  input  logic [POS_W-1:0]  cfgSlotSize,
  input  logic              bclkIn,
  input  logic              wsIn,
  input  logic              sdIn,
  output logic              bclkOut,
  output logic              wsOut,
  output logic              wrValid,
  output logic [DATA_W-1:0] wrData
);

  fmtCfg_t   portCfg;
  rxStrobe_t strb;

  assign portCfg = '{pol: cfgPolarity, mono: cfgMono, compact: cfgCompact,
                     pack8: cfgCompact8, sampleSz: cfgSampleSize, slotSz: cfgSlotSize};

  sarx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .cfgMaster (cfgMaster),
    .cfgDiv    (cfgClkDiv),
    .portCfg   (portCfg),
    .bclkIn    (bclkIn),
    .wsIn      (wsIn),
    .sdIn      (sdIn),
    .bclkOut   (bclkOut),
    .wsOut     (wsOut),
    .strb      (strb)
  );

  sarx_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrValid (wrValid),
    .wrData  (wrData)
  );

endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        cfgMaster = 1'b0;
  logic [7:0]  cfgClkDiv = 8'd0;
  logic        cfgPolarity = 1'b0;
  logic        cfgMono = 1'b0;
  logic        cfgCompact = 1'b0;
  logic        cfgCompact8 = 1'b0;
  logic [4:0]  cfgSampleSize = 5'd31;
  logic [4:0]  cfgSlotSize = 5'd31;
  logic        bclkIn = 1'b0;
  logic        wsIn = 1'b0;
  logic        sdIn = 1'b0;
  logic        bclkOut, wsOut, wrValid;
  logic [31:0] wrData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic carryBit = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  serial_audio_rx u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgMaster(cfgMaster), .cfgClkDiv(cfgClkDiv),
    .cfgPolarity(cfgPolarity), .cfgMono(cfgMono), .cfgCompact(cfgCompact),
    .cfgCompact8(cfgCompact8), .cfgSampleSize(cfgSampleSize), .cfgSlotSize(cfgSlotSize),
    .bclkIn(bclkIn), .wsIn(wsIn), .sdIn(sdIn), .bclkOut(bclkOut), .wsOut(wsOut),
    .wrValid(wrValid), .wrData(wrData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] actV, input logic [31:0] expV);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, actV, expV);
    end
  endtask

  function automatic logic [31:0] trunc(input logic [31:0] s, input int keepBits);
    if (keepBits >= 32) return s;
    return s & ~(32'hFFFF_FFFF >> keepBits);
  endfunction

  function automatic int keepOf(input int smp, input int slt);
    return ((smp < slt) ? smp : slt) + 1;
  endfunction

  function automatic logic [31:0] pack16(input logic [31:0] l, input logic [31:0] r);
    return {r[31:16], l[31:16]};
  endfunction

  function automatic logic [31:0] pack8(input logic [31:0] l, input logic [31:0] r);
    return {16'h0, r[31:24], l[31:24]};
  endfunction

  // Word monitor: compares each write with the expected queue
  always @(negedge clk) begin
    if (rstN && wrValid && !finished) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11", "unexpected word", wrData, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(wrData === e, t, "word", wrData, e);
      end
    end
  end

  task automatic expect_word(input logic [31:0] w, input string t);
    expQ.push_back(w);
    tagQ.push_back(t);
  endtask

  task automatic drive_bit(input logic ws, input logic sd);
    @(negedge clk);
    bclkIn = 1'b0; wsIn = ws; sdIn = sd;
    repeat (HALF) @(negedge clk);
    bclkIn = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  // One word-select phase; data lags word-select by one bit period
  task automatic send_slot(input logic ws, input logic [31:0] data, input int n);
    for (int b = 0; b < n; b++)
      drive_bit(ws, (b == 0) ? carryBit : data[32 - b]);
    carryBit = data[32 - n];
  endtask

  task automatic drain(input string t);
    repeat (40) @(negedge clk);
    check(expQ.size() == 0, t, "missing words", expQ.size(), 0);
    expQ.delete();
    tagQ.delete();
  endtask

  task automatic setup(input bit pol, input bit mono, input bit cmp, input bit c8,
                       input int smp, input int slt);
    @(negedge clk);
    enable = 1'b0;
    repeat (4) @(negedge clk);
    cfgPolarity = pol; cfgMono = mono; cfgCompact = cmp; cfgCompact8 = c8;
    cfgSampleSize = 5'(smp); cfgSlotSize = 5'(slt);
    @(negedge clk);
    enable = 1'b1;
  endtask

  // Junk right slot first (R4), then pairs, then a short left flush slot
  task automatic run_stream(input bit pol, input bit mono, input bit cmp, input bit c8,
                            input int smp, input int slt, input int pairs, input string t);
    int n, k;
    n = slt + 1;
    k = keepOf(smp, slt);
    setup(pol, mono, cmp, c8, smp, slt);
    send_slot(pol, $urandom(), n);
    for (int p = 0; p < pairs; p++) begin
      logic [31:0] l, r;
      l = $urandom();
      r = $urandom();
      if (cmp)       expect_word(c8 ? pack8(trunc(l, k), trunc(r, k)) : pack16(trunc(l, k), trunc(r, k)), t);
      else if (!mono) expect_word(trunc(l, k), t);
      send_slot(~pol, l, n);
      if (!cmp) expect_word(trunc(r, k), t);
      send_slot(pol, r, n);
    end
    send_slot(~pol, 32'h0, 2);
    drain(t);
  endtask

  task automatic finish_sim();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int seedInit;
    int cnt;
    seedInit = $urandom(32'd7719);
    repeat (3) @(negedge clk);
    check(wrValid === 1'b0, "R1", "wrValid in reset", 32'(wrValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(bclkOut === 1'b0 && wsOut === 1'b0, "R1", "generated clocks idle",
          {30'h0, bclkOut, wsOut}, 0);

    // R2: internal clock generation, divider 1, slot 8 bits
    cfgMaster = 1'b1; cfgClkDiv = 8'd1; cfgSlotSize = 5'd7; cfgSampleSize = 5'd3;
    sdIn = 1'b1;
    repeat (4) @(negedge clk);
    while (!(bclkOut === 1'b1)) @(negedge clk);
    while (bclkOut === 1'b1) @(negedge clk);
    cnt = 0;
    while (bclkOut === 1'b0) begin cnt++; @(negedge clk); end
    check(cnt == 2, "R2", "bclk low time", cnt, 2);
    cnt = 0;
    while (bclkOut === 1'b1) begin cnt++; @(negedge clk); end
    check(cnt == 2, "R2", "bclk high time", cnt, 2);
    begin
      logic wsOld, bPrev;
      wsOld = wsOut;
      while (wsOut === wsOld) @(negedge clk);
      wsOld = wsOut; bPrev = bclkOut; cnt = 0;
      while (wsOut === wsOld) begin
        @(negedge clk);
        if (bclkOut === 1'b1 && bPrev === 1'b0) cnt++;
        bPrev = bclkOut;
      end
      check(cnt == 8, "R2", "bit periods per ws phase", cnt, 8);
    end
    // R2 capture in internal mode: constant ones, 4-bit samples
    for (int i = 0; i < 4; i++) expect_word(32'hF000_0000, "R2");
    @(negedge clk);
    enable = 1'b1;
    while (expQ.size() != 0) @(negedge clk);
    enable = 1'b0;
    cfgMaster = 1'b0;
    drain("R2");

    // R3/R4/R5: full-width stereo, both polarities
    run_stream(1'b0, 1'b0, 1'b0, 1'b0, 31, 31, 3, "R5");
    run_stream(1'b1, 1'b0, 1'b0, 1'b0, 31, 31, 3, "R3");

    // R6: truncation corners (sample short, equal, slot short)
    run_stream(1'b0, 1'b0, 1'b0, 1'b0, 15, 31, 2, "R6");
    run_stream(1'b1, 1'b0, 1'b0, 1'b0, 23, 23, 2, "R6");
    run_stream(1'b0, 1'b0, 1'b0, 1'b0, 31, 15, 2, "R6");

    // R7: single-channel capture for both polarities
    run_stream(1'b0, 1'b1, 1'b0, 1'b0, 31, 31, 2, "R7");
    run_stream(1'b1, 1'b1, 1'b0, 1'b0, 19, 31, 2, "R7");

    // R8/R9: compact packing
    run_stream(1'b0, 1'b0, 1'b1, 1'b0, 31, 31, 3, "R8");
    run_stream(1'b1, 1'b0, 1'b1, 1'b0, 11, 23, 2, "R8");
    run_stream(1'b0, 1'b0, 1'b1, 1'b1, 31, 31, 3, "R9");
    run_stream(1'b1, 1'b1, 1'b1, 1'b1, 5, 15, 2, "R9");

    // R10: sample size changed mid-frame takes effect at next left slot
    begin
      logic [31:0] l1, r1, l2, r2;
      l1 = $urandom(); r1 = $urandom(); l2 = $urandom(); r2 = $urandom();
      setup(1'b0, 1'b0, 1'b0, 1'b0, 31, 31);
      send_slot(1'b0, 32'hDEAD_BEEF, 32);
      expect_word(l1, "R10");
      send_slot(1'b1, l1, 32);
      cfgSampleSize = 5'd7;
      expect_word(r1, "R10");
      send_slot(1'b0, r1, 32);
      expect_word(trunc(l2, 8), "R10");
      send_slot(1'b1, l2, 32);
      expect_word(trunc(r2, 8), "R10");
      send_slot(1'b0, r2, 32);
      send_slot(1'b1, 32'h0, 2);
      drain("R10");
    end

    // R11: disable drops a half pair and blocks words while low
    begin
      logic [31:0] l2, r2;
      l2 = $urandom(); r2 = $urandom();
      setup(1'b0, 1'b0, 1'b1, 1'b0, 31, 31);
      send_slot(1'b0, 32'h1234_5678, 32);
      send_slot(1'b1, 32'hAAAA_5555, 32);
      send_slot(1'b0, 32'h0, 1);
      @(negedge clk);
      enable = 1'b0;
      send_slot(1'b0, 32'h0, 31);
      send_slot(1'b1, 32'hFFFF_0000, 32);
      send_slot(1'b0, 32'h0F0F_F0F0, 32);
      @(negedge clk);
      enable = 1'b1;
      send_slot(1'b0, 32'h5A5A_5A5A, 32);
      expect_word(pack16(l2, r2), "R11");
      send_slot(1'b1, l2, 32);
      send_slot(1'b0, r2, 32);
      send_slot(1'b1, 32'h0, 2);
      drain("R11");
    end

    // Constrained random formats (R6, R7, R8, R9)
    for (int t = 0; t < 6; t++) begin
      int smp, slt;
      bit pol, mono, cmp, c8;
      smp = 3 + ($urandom() % 29);
      slt = 7 + ($urandom() % 25);
      pol = 1'($urandom()); mono = 1'($urandom());
      cmp = 1'($urandom()); c8 = 1'($urandom());
      run_stream(pol, mono, cmp, c8, smp, slt, 2, cmp ? (c8 ? "R9" : "R8") : (mono ? "R7" : "R6"));
    end

    finish_sim();
  end

endmodule